// File: doc/BRIEF.md
# XGMII to 64b/66b Block Encoder

This block turns one eight-lane XGMII word per clock into a 66-bit line block made of a 2-bit sync header and a 64-bit payload. Each input byte lane comes with a control bit. A word with no control lanes goes out unchanged behind the data header. Any other word goes out behind the control header, with a block type byte in payload byte 0. The remaining payload bits then hold a mix of data bytes, 7-bit line codes and 4-bit ordered-set codes. Their layout depends on where the start, terminate and ordered-set characters sit. Lane patterns that no special layout can carry fall back to an all-control block.

The encoder sits between a MAC-side XGMII source and a scrambler. It has one registered output stage. The `in_valid` qualifier lets a rate-adapted upstream skip cycles: a cycle without `in_valid` leaves the output block unchanged and drops `out_valid`.

XGMII characters used here: idle 0x07, start 0xFB, terminate 0xFD, error 0xFE, sequence ordered set 0x9C, signal ordered set 0x5C.

Top module: `xenc_encoder`

## Requirements
- R1: When `in_ctrl` is 0, the block is sent with header 2'b01 and a payload equal to `in_data`. Lane k sits in payload bits 8k+7..8k.
- R2: When any `in_ctrl` bit is 1, the block is sent with header 2'b10 and a block type code in payload bits 7..0.
- R3: Line codes for lanes are computed as follows:
  - The line code of a lane whose control bit is set is: idle→0x00, error→0x1E, 0x1C→0x2D, 0x3C→0x33, 0x7C→0x4B, 0xBC→0x55, 0xDC→0x66, 0xF7→0x78, and any other character→0x1E.
  - A lane without its control bit set, in a position that needs a code, gets 0x1E.
  - In the all-control block (type 0x1E), the code of lane k sits at payload bits 8+7k+6..8+7k.
- R4: Start in lane 0 with lanes 1–7 data gives type 0x78, with lanes 1–7 in payload bytes 1–7.
- R5: Start in lane 4 with lanes 5–7 data, when lane 0 is not an ordered set with lanes 1–3 data, gives type 0x33. The codes of lanes 0–3 sit at bits 8+7k, bits 39..36 are 0, and lanes 5–7 are in bytes 5–7.
- R6: Start in lane 4 with lanes 5–7 data, plus an ordered set in lane 0 with lanes 1–3 data, gives type 0x66. Lanes 1–3 go in bytes 1–3, the lane 0 O code in bits 35..32, 0 in bits 39..36, and lanes 5–7 in bytes 5–7.
- R7: Ordered-set blocks use an O code of 0x0 for a sequence set and 0xF for a signal set. The lane 0 O code sits in bits 35..32 and the lane 4 O code in bits 39..36.
  - Ordered sets in both lane 0 and lane 4 give type 0x55, carrying data lanes 1–3 and 5–7 in their bytes.
  - An ordered set in lane 0 only gives type 0x4B, with the codes of lanes 4–7 at bits 8+7k.
  - An ordered set in lane 4 only gives type 0x2D, with the codes of lanes 0–3 at bits 8+7k and lanes 5–7 in bytes 5–7.
  - An ordered set counts only when its following three lanes are data.
- R8: A terminate in lane n, with lanes 0..n-1 data, gives type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for n = 0..7. Lane k<n goes in byte k+1, the code of each lane k>n goes at bits 8+7k, and all other bits are 0.
- R9: Patterns are checked in this priority: start lane 0, start lane 4, ordered set lane 0, ordered set lane 4, terminate. Any control word matching none of them is sent as type 0x1E.
- R10: Output registers load one clock after a cycle with `in_valid` high, and `out_valid` is high for exactly those cycles. A cycle with `in_valid` low leaves `out_header` and `out_payload` unchanged.
- R11: While `rst` is high, the output is `out_valid` 0, `out_header` 2'b10 and `out_payload` 0x1E (an all-idle control block).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier; low stalls the stage |
| in_data | input | 64 | XGMII data, lane k in bits 8k+7..8k |
| in_ctrl | input | 8 | XGMII control mask, bit k for lane k |
| out_valid | output | 1 | Output block was loaded last cycle |
| out_header | output | 2 | Sync header, 2'b01 data, 2'b10 control |
| out_payload | output | 64 | Block payload |

## Verification
The bench walks a terminate through all eight lanes. A wrong lane-to-type table or an off-by-one byte packing would show up as a wrong type byte or shifted data there. It pairs sequence and signal ordered sets in lane 0 and lane 4, so a swapped O-nibble position or a missing lane 0 nibble in the two-ordered-set block is exposed. It places data bytes in lanes that need codes, and stray starts or terminates behind control lanes, so a design that skips the error substitution or the all-control fallback emits an illegal type or raw data. Random lane mixes with random stalls catch a pipeline that loads on invalid cycles or loses the held block.

// File: rtl/xenc_pkg.sv
package xenc_pkg;

    localparam int LANES  = 8;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 7;
    localparam int ONIB_W = 4;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int HDR_W  = 2;
    localparam int LIDX_W = $clog2(LANES);

    localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
    localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [BYTE_W-1:0] CH_ERROR = 8'hFE;
    localparam logic [BYTE_W-1:0] CH_SEQ   = 8'h9C;
    localparam logic [BYTE_W-1:0] CH_SIG   = 8'h5C;

    localparam logic [CODE_W-1:0] LC_IDLE  = 7'h00;
    localparam logic [CODE_W-1:0] LC_ERROR = 7'h1E;

    localparam logic [HDR_W-1:0] SH_DATA = 2'b01;
    localparam logic [HDR_W-1:0] SH_CTRL = 2'b10;

    typedef enum logic [BYTE_W-1:0] {
        BT_CTRL  = 8'h1E,
        BT_S0    = 8'h78,
        BT_S4    = 8'h33,
        BT_OS_S  = 8'h66,
        BT_OS_OS = 8'h55,
        BT_OS0   = 8'h4B,
        BT_OS4   = 8'h2D,
        BT_T0    = 8'h87,
        BT_T1    = 8'h99,
        BT_T2    = 8'hAA,
        BT_T3    = 8'hB4,
        BT_T4    = 8'hCC,
        BT_T5    = 8'hD2,
        BT_T6    = 8'hE1,
        BT_T7    = 8'hFF
    } block_type_e;

    typedef enum logic [3:0] {
        K_DATA, K_CTRL, K_S0, K_S4, K_OS_S, K_OS_OS, K_OS0, K_OS4, K_TERM
    } kind_e;

    typedef struct packed {
        logic              ctl;
        logic              is_start;
        logic              is_term;
        logic              is_os;
        logic [CODE_W-1:0] code;
        logic [ONIB_W-1:0] onib;
    } lane_info_t;

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [WORD_W-1:0] payload;
    } block_t;

    function automatic logic [CODE_W-1:0] line_code(input logic [BYTE_W-1:0] ch);
        case (ch)
            CH_IDLE:  return LC_IDLE;
            8'h1C:    return 7'h2D;
            8'h3C:    return 7'h33;
            8'h7C:    return 7'h4B;
            8'hBC:    return 7'h55;
            8'hDC:    return 7'h66;
            8'hF7:    return 7'h78;
            default:  return LC_ERROR;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] term_type(input logic [LIDX_W-1:0] lane);
        case (lane)
            3'd0:    return BT_T0;
            3'd1:    return BT_T1;
            3'd2:    return BT_T2;
            3'd3:    return BT_T3;
            3'd4:    return BT_T4;
            3'd5:    return BT_T5;
            3'd6:    return BT_T6;
            default: return BT_T7;
        endcase
    endfunction

endpackage

// File: rtl/xenc_lane_decode.sv
module xenc_lane_decode
    import xenc_pkg::*;
(
    input  logic [BYTE_W-1:0] ch,
    input  logic              ctl,
    output lane_info_t        info
);
    always_comb begin
        info.ctl      = ctl;
        info.is_start = ctl && (ch == CH_START);
        info.is_term  = ctl && (ch == CH_TERM);
        info.is_os    = ctl && ((ch == CH_SEQ) || (ch == CH_SIG));
        info.code     = ctl ? line_code(ch) : LC_ERROR;
        info.onib     = (ch == CH_SIG) ? 4'hF : 4'h0;
    end
endmodule

// File: rtl/xenc_classify.sv
module xenc_classify
    import xenc_pkg::*;
(
    input  lane_info_t [LANES-1:0] info,
    output kind_e                  kind,
    output logic [LIDX_W-1:0]      term_lane
);
    logic [LANES-1:0]  c;
    logic [LIDX_W-1:0] first;
    logic              os0_ok, os4_ok;

    always_comb begin
        for (int i = 0; i < LANES; i++) c[i] = info[i].ctl;
        first = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (c[i]) first = LIDX_W'(i);
        end
    end

    assign os0_ok = info[0].is_os && (c[3:1] == 3'b000);
    assign os4_ok = info[4].is_os && (c[7:5] == 3'b000);

    always_comb begin
        term_lane = first;
        if (c == '0)                                     kind = K_DATA;
        else if (info[0].is_start && c[7:1] == 7'd0)     kind = K_S0;
        else if (info[4].is_start && c[7:5] == 3'd0)     kind = os0_ok ? K_OS_S : K_S4;
        else if (os0_ok)                                 kind = os4_ok ? K_OS_OS : K_OS0;
        else if (os4_ok)                                 kind = K_OS4;
        else if (info[first].is_term)                    kind = K_TERM;
        else                                             kind = K_CTRL;
    end
endmodule

// File: rtl/xenc_pack.sv
module xenc_pack
    import xenc_pkg::*;
(
    input  logic [WORD_W-1:0]      data,
    input  lane_info_t [LANES-1:0] info,
    input  kind_e                  kind,
    input  logic [LIDX_W-1:0]      term_lane,
    output block_t                 blk
);
    logic [WORD_W-1:0] p;
    logic [HDR_W-1:0]  h;

    always_comb begin
        p = '0;
        h = SH_CTRL;
        case (kind)
            K_DATA: begin
                h = SH_DATA;
                p = data;
            end
            K_S0: begin
                p       = data;
                p[7:0]  = BT_S0;
            end
            K_S4: begin
                p[7:0] = BT_S4;
                for (int i = 0; i < 4; i++) p[8+CODE_W*i +: CODE_W] = info[i].code;
                p[63:40] = data[63:40];
            end
            K_OS_S: begin
                p[7:0]   = BT_OS_S;
                p[31:8]  = data[31:8];
                p[35:32] = info[0].onib;
                p[63:40] = data[63:40];
            end
            K_OS_OS: begin
                p[7:0]   = BT_OS_OS;
                p[31:8]  = data[31:8];
                p[35:32] = info[0].onib;
                p[39:36] = info[4].onib;
                p[63:40] = data[63:40];
            end
            K_OS0: begin
                p[7:0]   = BT_OS0;
                p[31:8]  = data[31:8];
                p[35:32] = info[0].onib;
                for (int i = 4; i < LANES; i++) p[8+CODE_W*i +: CODE_W] = info[i].code;
            end
            K_OS4: begin
                p[7:0] = BT_OS4;
                for (int i = 0; i < 4; i++) p[8+CODE_W*i +: CODE_W] = info[i].code;
                p[39:36] = info[4].onib;
                p[63:40] = data[63:40];
            end
            K_TERM: begin
                p[7:0] = term_type(term_lane);
                for (int i = 0; i < LANES - 1; i++) begin
                    if (LIDX_W'(i) < term_lane) p[8+BYTE_W*i +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
                end
                for (int i = 1; i < LANES; i++) begin
                    if (LIDX_W'(i) > term_lane) p[8+CODE_W*i +: CODE_W] = info[i].code;
                end
            end
            default: begin
                p[7:0] = BT_CTRL;
                for (int i = 0; i < LANES; i++) p[8+CODE_W*i +: CODE_W] = info[i].code;
            end
        endcase
        blk.hdr     = h;
        blk.payload = p;
    end
endmodule

// File: rtl/xenc_encoder.sv
module xenc_encoder
    import xenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_ctrl,
    output logic              out_valid,
    output logic [HDR_W-1:0]  out_header,
    output logic [WORD_W-1:0] out_payload
);
    lane_info_t [LANES-1:0] info;
    kind_e                  kind;
    logic [LIDX_W-1:0]      term_lane;
    block_t                 blk_next;
    block_t                 blk_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xenc_lane_decode u_dec (
            .ch   (in_data[BYTE_W*g +: BYTE_W]),
            .ctl  (in_ctrl[g]),
            .info (info[g])
        );
    end

    xenc_classify u_cls (
        .info      (info),
        .kind      (kind),
        .term_lane (term_lane)
    );

    xenc_pack u_pack (
        .data      (in_data),
        .info      (info),
        .kind      (kind),
        .term_lane (term_lane),
        .blk       (blk_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            blk_q.hdr     <= SH_CTRL;
            blk_q.payload <= {{(WORD_W-BYTE_W){1'b0}}, BT_CTRL};
        end else begin
            out_valid <= in_valid;
            if (in_valid) blk_q <= blk_next;
        end
    end

    assign out_header  = blk_q.hdr;
    assign out_payload = blk_q.payload;
endmodule

// File: rtl/xenc_encoder_checks.sv
module xenc_encoder_checks (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic [7:0]  in_ctrl,
    input logic        out_valid,
    input logic [1:0]  out_header,
    input logic [63:0] out_payload
);
    // R1: all-data word passes through behind the data header
    p_data_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl == 8'h00) |=> (out_header == 2'b01 && out_payload == $past(in_data)));

    // R2: any control lane selects the control header
    p_ctrl_hdr_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl != 8'h00) |=> (out_header == 2'b10));

    // R2: header is always one of the two legal values
    p_hdr_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (out_header == 2'b01) || (out_header == 2'b10));

    // R4: start in lane 0 followed by data
    p_start0_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl == 8'h01 && in_data[7:0] == 8'hFB)
        |=> (out_payload == {$past(in_data[63:8]), 8'h78}));

    // R8: terminate in lane 7 after seven data lanes
    p_term7_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl == 8'h80 && in_data[63:56] == 8'hFD)
        |=> (out_payload == {$past(in_data[55:0]), 8'hFF}));

    // R10: valid follows the input qualifier
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10: a stalled cycle holds the output block
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_payload) && $stable(out_header)));
endmodule

bind xenc_encoder xenc_encoder_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ctrl     (in_ctrl),
    .out_valid   (out_valid),
    .out_header  (out_header),
    .out_payload (out_payload)
);

// File: tb/xenc_encoder_test.sv
`timescale 1ns/1ps
module xenc_encoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        out_valid;
    logic [1:0]  out_header;
    logic [63:0] out_payload;

    always #2 clk = ~clk;

    xenc_encoder uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ctrl     (in_ctrl),
        .out_valid   (out_valid),
        .out_header  (out_header),
        .out_payload (out_payload)
    );

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    done   = 0;
    logic        e_valid = 1'b0;
    logic [1:0]  e_hdr   = 2'b10;
    logic [63:0] e_pay   = 64'h1E;
    string       e_tag   = "R11";
    logic [63:0] dw;
    logic [7:0]  cw;

    // ---------------- reference model ----------------
    function automatic logic [6:0] ref_code(logic [7:0] ch, logic is_c);
        if (!is_c) return 7'h1E;
        if (ch == 8'h07) return 7'h00;
        if (ch == 8'h1C) return 7'h2D;
        if (ch == 8'h3C) return 7'h33;
        if (ch == 8'h7C) return 7'h4B;
        if (ch == 8'hBC) return 7'h55;
        if (ch == 8'hDC) return 7'h66;
        if (ch == 8'hF7) return 7'h78;
        return 7'h1E;
    endfunction

    function automatic logic [65:0] ref_block(logic [63:0] d, logic [7:0] c);
        logic [7:0]  b [8];
        logic [63:0] p = '0;
        logic [7:0]  tt [8];
        bit os0, os4, st4;
        int first = 8;
        tt[0]=8'h87; tt[1]=8'h99; tt[2]=8'hAA; tt[3]=8'hB4;
        tt[4]=8'hCC; tt[5]=8'hD2; tt[6]=8'hE1; tt[7]=8'hFF;
        for (int i = 0; i < 8; i++) b[i] = d[8*i +: 8];
        if (c == 8'h00) return {2'b01, d};
        for (int i = 7; i >= 0; i--) if (c[i]) first = i;
        os0 = c[0] && (b[0] == 8'h9C || b[0] == 8'h5C) && c[3:1] == 0;
        os4 = c[4] && (b[4] == 8'h9C || b[4] == 8'h5C) && c[7:5] == 0;
        st4 = c[4] && b[4] == 8'hFB && c[7:5] == 0;
        if (c[0] && b[0] == 8'hFB && c[7:1] == 0) begin
            p = {d[63:8], 8'h78};
        end else if (st4 || os0 || os4) begin
            if (st4 && os0)      p[7:0] = 8'h66;
            else if (st4)        p[7:0] = 8'h33;
            else if (os0 && os4) p[7:0] = 8'h55;
            else if (os0)        p[7:0] = 8'h4B;
            else                 p[7:0] = 8'h2D;
            if (os0) begin
                p[31:8]  = d[31:8];
                p[35:32] = (b[0] == 8'h5C) ? 4'hF : 4'h0;
            end else begin
                for (int i = 0; i < 4; i++) p[8+7*i +: 7] = ref_code(b[i], c[i]);
            end
            if (st4 || os4) begin
                p[63:40] = d[63:40];
                if (os4 && !st4) p[39:36] = (b[4] == 8'h5C) ? 4'hF : 4'h0;
            end else begin
                for (int i = 4; i < 8; i++) p[8+7*i +: 7] = ref_code(b[i], c[i]);
            end
        end else if (b[first] == 8'hFD) begin
            p[7:0] = tt[first];
            for (int i = 0; i < first; i++) p[8*(i+1) +: 8] = b[i];
            for (int i = first + 1; i < 8; i++) p[8+7*i +: 7] = ref_code(b[i], c[i]);
        end else begin
            p[7:0] = 8'h1E;
            for (int i = 0; i < 8; i++) p[8+7*i +: 7] = ref_code(b[i], c[i]);
        end
        return {2'b10, p};
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic fill_idle();
        dw = {8{8'h07}};
        cw = 8'hFF;
    endtask

    task automatic put_ctl(int lane, logic [7:0] ch);
        dw[8*lane +: 8] = ch;
        cw[lane] = 1'b1;
    endtask

    task automatic put_data(int lane);
        dw[8*lane +: 8] = 8'($urandom);
        cw[lane] = 1'b0;
    endtask

    task automatic check_now();
        bit bad = 0;
        n_vec++;
        if (out_valid !== e_valid) begin
            $display("FAIL %s out_valid actual=%b expected=%b", e_tag, out_valid, e_valid); bad = 1;
        end
        if (out_header !== e_hdr) begin
            $display("FAIL %s out_header actual=%b expected=%b", e_tag, out_header, e_hdr); bad = 1;
        end
        if (out_payload !== e_pay) begin
            $display("FAIL %s out_payload actual=%h expected=%h", e_tag, out_payload, e_pay); bad = 1;
        end
        if (bad) n_bad++;
    endtask

    // check the previous expectation, then drive the next word
    task automatic apply(logic v, string tag);
        @(negedge clk);
        check_now();
        in_valid = v;
        in_data  = dw;
        in_ctrl  = cw;
        e_valid  = v;
        if (v) {e_hdr, e_pay} = ref_block(dw, cw);
        e_tag = tag;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=completion");
            n_bad++;
            finish_run();
        end
    end

    initial begin
        dw = '0; cw = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state observed on first check
        check_now();
        rst = 1'b0;

        // R1: all-data words
        dw = 64'h0; cw = 8'h00; apply(1, "R1");
        for (int k = 0; k < 4; k++) begin
            dw = {$urandom, $urandom}; cw = 8'h00; apply(1, "R1");
        end
        // R2 / R3: all idle, all error, reserved characters
        fill_idle(); apply(1, "R3");
        dw = {8{8'hFE}}; cw = 8'hFF; apply(1, "R3");
        dw = {8'h07, 8'hF7, 8'hDC, 8'hBC, 8'h7C, 8'h3C, 8'h1C, 8'hFE}; cw = 8'hFF; apply(1, "R3");
        fill_idle(); put_ctl(3, 8'h00); put_ctl(6, 8'h42); apply(1, "R3");
        fill_idle(); put_data(2); put_data(5); apply(1, "R3");
        for (int k = 0; k < 8; k++) begin
            dw = {$urandom, $urandom}; cw = 8'(1 << k); dw[8*k +: 8] = 8'h07; apply(1, "R2");
        end
        // R4: start in lane 0
        for (int k = 0; k < 3; k++) begin
            for (int i = 1; i < 8; i++) put_data(i);
            put_ctl(0, 8'hFB); apply(1, "R4");
        end
        // R5: start in lane 4
        fill_idle(); for (int i = 5; i < 8; i++) put_data(i); put_ctl(4, 8'hFB); apply(1, "R5");
        fill_idle(); for (int i = 5; i < 8; i++) put_data(i); put_ctl(4, 8'hFB); put_data(1); apply(1, "R5");
        fill_idle(); for (int i = 5; i < 8; i++) put_data(i); put_ctl(4, 8'hFB); put_ctl(0, 8'h9C); put_ctl(2, 8'h07); apply(1, "R5");
        // R6: ordered set plus start
        for (int k = 0; k < 2; k++) begin
            for (int i = 1; i < 8; i++) put_data(i);
            put_ctl(0, k == 0 ? 8'h9C : 8'h5C); put_ctl(4, 8'hFB); apply(1, "R6");
        end
        // R7: ordered set combinations
        for (int k = 0; k < 4; k++) begin
            for (int i = 1; i < 8; i++) put_data(i);
            put_ctl(0, k[0] ? 8'h5C : 8'h9C); put_ctl(4, k[1] ? 8'h5C : 8'h9C); apply(1, "R7");
        end
        for (int k = 0; k < 2; k++) begin
            fill_idle(); for (int i = 1; i < 4; i++) put_data(i);
            put_ctl(0, k == 0 ? 8'h9C : 8'h5C); apply(1, "R7");
            fill_idle(); for (int i = 5; i < 8; i++) put_data(i);
            put_ctl(4, k == 0 ? 8'h9C : 8'h5C); apply(1, "R7");
        end
        // R8: terminate in each lane
        for (int n = 0; n < 8; n++) begin
            fill_idle();
            for (int i = 0; i < n; i++) put_data(i);
            put_ctl(n, 8'hFD); apply(1, "R8");
        end
        fill_idle(); put_data(0); put_ctl(1, 8'hFD); put_data(5); apply(1, "R8");
        // R9: priority and fallback
        fill_idle(); put_data(0); put_data(1); put_ctl(2, 8'hFB); apply(1, "R9");
        fill_idle(); put_ctl(0, 8'h07); put_ctl(3, 8'hFD); put_data(1); put_data(2); apply(1, "R9");
        for (int i = 1; i < 8; i++) put_data(i); put_ctl(0, 8'hFB); put_ctl(5, 8'h07); apply(1, "R9");
        fill_idle(); put_ctl(0, 8'h9C); put_ctl(4, 8'hFB); for (int i = 5; i < 8; i++) put_data(i); put_ctl(2, 8'hFD); apply(1, "R9");
        // R10: stalls hold the output
        for (int i = 0; i < 8; i++) put_data(i); apply(1, "R10");
        for (int k = 0; k < 4; k++) begin
            dw = {$urandom, $urandom}; cw = 8'($urandom); apply(0, "R10");
        end
        fill_idle(); apply(1, "R10");
        apply(0, "R10");
        // R9: random lane mixes with random stalls
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < 8; i++) begin
                case ($urandom % 10)
                    0, 1, 2, 3: put_data(i);
                    4: put_ctl(i, 8'h07);
                    5: put_ctl(i, 8'hFB);
                    6: put_ctl(i, 8'hFD);
                    7: put_ctl(i, 8'h9C);
                    8: put_ctl(i, 8'h5C);
                    default: put_ctl(i, ($urandom % 2) ? 8'hFE : 8'h3C);
                endcase
            end
            apply(($urandom % 5) != 0, "R9");
        end
        apply(0, "R10");
        @(negedge clk);
        check_now();
        finish_run();
    end
endmodule